// File: doc/BRIEF.md
# Sliding-Window Traffic Profiler

This block watches one traffic stream that presents a count of data units every clock cycle. From that stream it measures the two parameters of a linear arrival-curve envelope: an average rate and a burst allowance, the amount by which the cumulative traffic runs ahead of a straight line at that rate. It then extrapolates both values one step ahead and hands the result to a downstream traffic regulator. Window lengths are powers of two: `2**LSW_LG` cycles per sampling window and `2**(LSW_LG-N_LG)` cycles between updates.

Measurement runs in `2**N_LG` window engines whose starts are staggered by one update interval. The sampling windows therefore overlap, and one of them closes every update interval. The engine that has just closed is routed through a selector into a shared prediction stage. That stage keeps the previous measurement and forms a linear extrapolation. The predicted values are clamped to a range a regulator can use.

Rates are fixed-point with `FRAC` fractional bits, and the burst allowance uses the same scaling. With the defaults this gives 8 fractional bits, a 32-cycle sampling window, 4 engines and an update every 8 cycles.

Top module: `flow_profiler`

## Requirements
- R1: Counting enabled cycles from 0 at the first rising edge with `en` high, window j covers cycles j*LPW up to j*LPW+LSW-1. A window therefore closes every LPW cycles, and no two engines ever close in the same cycle.
- R2: The measured rate of a window is floor(F*2^FRAC/LSW), where F is the sum of all counts in the window. It carries FRAC fractional bits, so 1 unit per cycle reads as 2^FRAC.
- R3: The measured burst of window j is the largest of 0 and F(t)*2^FRAC - ref*t over t = 1..LSW. F(t) is the sum of the first t counts of the window, and ref is the measured rate of window j-N, or 0 when j < N.
- R4: Each prediction applies the same rule to rate and to burst: twice the newest measurement minus the one before it.
- R5: The predicted rate is clamped to 0..2^FRAC, so it never exceeds 1 unit per cycle. The predicted burst is clamped to 0..2^SIG_W-1.
- R6: `pred_valid` pulses for exactly one cycle. It is high after the rising edge of enabled cycle j*LPW+LSW for each j >= 1, and never for window 0 alone.
- R7: While `en` is low, all engines and the prediction history are cleared and `pred_valid` stays low. After `en` rises again, the block behaves as it did after reset.
- R8: A synchronous active-high `rst` forces `pred_valid`, `sigma_pred` and `rho_pred` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears engines and history |
| cnt_in | input | CNT_W | Data units seen this cycle |
| sigma_pred | output | SIG_W | Predicted burst allowance, FRAC fractional bits |
| rho_pred | output | FRAC+1 | Predicted rate, FRAC fractional bits, at most 1.0 |
| pred_valid | output | 1 | One-cycle strobe when a new prediction is presented |

## Verification
A window engine closes in the same cycle in which `en` falls. The prediction stage then receives a completed measurement and a clear request together, and the clear must win. The bench provokes this by dropping `en` in the cycle right after window 1 closes. It checks that no strobe appears, and that after re-enabling, the first strobe comes only after two fresh windows. A second collision occurs inside each engine: the last sample of one window and the first sample of the next, which uses a new reference rate, fall in adjacent cycles. A constant stream, whose burst drops to zero once the reference rate catches up, exposes an off-by-one there.

// File: rtl/flowprof_pkg.sv
package flowprof_pkg;
  typedef enum logic [1:0] {
    HIST_NONE  = 2'd0,
    HIST_ONE   = 2'd1,
    HIST_READY = 2'd2
  } hist_e;
endpackage

// File: rtl/flowprof_stagger.sv
module flowprof_stagger #(
  parameter int N   = 4,
  parameter int LPW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] active
);
  localparam int LAST = (N - 1) * LPW;
  localparam int LCW  = $clog2(LAST + 2);

  logic [LCW-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) lcnt <= '0;
    else if (lcnt != LCW'(LAST)) lcnt <= lcnt + 1'b1;
  end

  for (genvar k = 0; k < N; k++) begin : g_start
    localparam int START = k * LPW;
    assign active[k] = en && (lcnt >= LCW'(START));
  end
endmodule

// File: rtl/flowprof_engine.sv
module flowprof_engine #(
  parameter int CNT_W  = 4,
  parameter int FRAC   = 8,
  parameter int LSW_LG = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        act,
  input  logic [CNT_W-1:0]            cnt,
  output logic                        done,
  output logic [CNT_W+LSW_LG+FRAC-1:0] sigma_o,
  output logic [CNT_W+FRAC-1:0]       rho_o
);
  localparam int FW    = CNT_W + LSW_LG;
  localparam int RHO_W = CNT_W + FRAC;
  localparam int SIG_W = FW + FRAC;
  localparam int RW    = RHO_W + LSW_LG;
  localparam int DW    = ((SIG_W > RW) ? SIG_W : RW) + 1;

  logic [LSW_LG-1:0] ofs;
  logic [FW-1:0]     facc, f_now;
  logic [RW-1:0]     racc, r_now;
  logic [SIG_W-1:0]  smax, d_pos, s_new, f_fx;
  logic [RHO_W-1:0]  rho_ref, rate_new;
  logic signed [DW-1:0] fx, rx, d;
  logic last;

  always_comb begin
    f_now    = facc + {{LSW_LG{1'b0}}, cnt};
    r_now    = racc + {{LSW_LG{1'b0}}, rho_ref};
    f_fx     = {f_now, {FRAC{1'b0}}};
    fx       = {{(DW-SIG_W){1'b0}}, f_fx};
    rx       = {{(DW-RW){1'b0}}, r_now};
    d        = fx - rx;
    d_pos    = (d > 0) ? d[SIG_W-1:0] : '0;
    s_new    = (d_pos > smax) ? d_pos : smax;
    rate_new = f_fx[SIG_W-1:LSW_LG];
    last     = (ofs == '1);
  end

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      ofs <= '0; facc <= '0; racc <= '0; smax <= '0; rho_ref <= '0;
      done <= 1'b0; sigma_o <= '0; rho_o <= '0;
    end else begin
      done <= last;
      ofs  <= ofs + 1'b1;
      if (last) begin
        sigma_o <= s_new;
        rho_o   <= rate_new;
        rho_ref <= rate_new;
        facc    <= '0;
        racc    <= '0;
        smax    <= '0;
      end else begin
        facc <= f_now;
        racc <= r_now;
        smax <= s_new;
      end
    end
  end

  // R1: a window closes once, then the engine starts its next window
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: the running peak never falls inside a window
  assert_peak_monotone_R3: assert property (@(posedge clk) disable iff (rst)
    (act && !last && $past(act) && ofs != '0) |-> (smax >= $past(smax)));
endmodule

// File: rtl/flowprof_predict.sv
module flowprof_predict #(
  parameter int SIG_W = 17,
  parameter int RHO_W = 12,
  parameter int FRAC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             in_valid,
  input  logic [SIG_W-1:0] sig_in,
  input  logic [RHO_W-1:0] rho_in,
  output logic [SIG_W-1:0] sigma_pred,
  output logic [FRAC:0]    rho_pred,
  output logic             valid
);
  import flowprof_pkg::*;

  localparam logic signed [SIG_W+1:0] SMAX = {2'b00, {SIG_W{1'b1}}};
  localparam logic signed [RHO_W+1:0] RONE =
    {{(RHO_W+1-FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};

  hist_e            hist;
  logic [SIG_W-1:0] prev_s, s_clip;
  logic [RHO_W-1:0] prev_r;
  logic [FRAC:0]    r_clip;
  logic signed [SIG_W+1:0] es;
  logic signed [RHO_W+1:0] er;

  always_comb begin
    es = $signed({1'b0, sig_in, 1'b0}) - $signed({2'b00, prev_s});
    er = $signed({1'b0, rho_in, 1'b0}) - $signed({2'b00, prev_r});
    if (es < 0)          s_clip = '0;
    else if (es > SMAX)  s_clip = '1;
    else                 s_clip = es[SIG_W-1:0];
    if (er < 0)          r_clip = '0;
    else if (er > RONE)  r_clip = RONE[FRAC:0];
    else                 r_clip = er[FRAC:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hist <= HIST_NONE; prev_s <= '0; prev_r <= '0;
      valid <= 1'b0; sigma_pred <= '0; rho_pred <= '0;
    end else begin
      valid <= 1'b0;
      if (in_valid) begin
        prev_s <= sig_in;
        prev_r <= rho_in;
        if (hist == HIST_NONE) hist <= HIST_ONE;
        else begin
          hist       <= HIST_READY;
          valid      <= 1'b1;
          sigma_pred <= s_clip;
          rho_pred   <= r_clip;
        end
      end
    end
  end

  // R5: predicted rate never above one unit per cycle
  assert_rate_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rho_pred <= RONE[FRAC:0]));
  // R6: every strobe follows a closing window and lasts one cycle
  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(in_valid));
  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R7: disable suppresses the strobe
  assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid);
endmodule

// File: rtl/flow_profiler.sv
module flow_profiler #(
  parameter int CNT_W  = 4,
  parameter int FRAC   = 8,
  parameter int LSW_LG = 5,
  parameter int N_LG   = 2,
  parameter int SIG_W  = CNT_W + LSW_LG + FRAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [SIG_W-1:0] sigma_pred,
  output logic [FRAC:0]    rho_pred,
  output logic             pred_valid
);
  localparam int N     = 1 << N_LG;
  localparam int LPW   = 1 << (LSW_LG - N_LG);
  localparam int RHO_W = CNT_W + FRAC;

  logic [N-1:0]     active, done;
  logic [SIG_W-1:0] e_sig [N];
  logic [RHO_W-1:0] e_rho [N];
  logic [SIG_W-1:0] sel_sig;
  logic [RHO_W-1:0] sel_rho;
  logic             any_done;

  flowprof_stagger #(.N(N), .LPW(LPW)) u_stagger (
    .clk(clk), .rst(rst), .en(en), .active(active));

  for (genvar k = 0; k < N; k++) begin : g_eng
    flowprof_engine #(.CNT_W(CNT_W), .FRAC(FRAC), .LSW_LG(LSW_LG)) u_eng (
      .clk(clk), .rst(rst), .act(active[k]), .cnt(cnt_in),
      .done(done[k]), .sigma_o(e_sig[k]), .rho_o(e_rho[k]));
  end

  always_comb begin
    sel_sig = '0;
    sel_rho = '0;
    for (int k = 0; k < N; k++) begin
      if (done[k]) begin
        sel_sig = e_sig[k];
        sel_rho = e_rho[k];
      end
    end
    any_done = |done;
  end

  flowprof_predict #(.SIG_W(SIG_W), .RHO_W(RHO_W), .FRAC(FRAC)) u_pred (
    .clk(clk), .rst(rst), .en(en), .in_valid(any_done),
    .sig_in(sel_sig), .rho_in(sel_rho),
    .sigma_pred(sigma_pred), .rho_pred(rho_pred), .valid(pred_valid));

  // R1: staggered engines never close together
  assert_single_close_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done));
endmodule

// File: tb/flow_profiler_test.sv
module flow_profiler_test;
  localparam int CNT_W = 4, FRAC = 8, LSW_LG = 5, N_LG = 2;
  localparam int SIG_W = CNT_W + LSW_LG + FRAC;
  localparam int LSW = 1 << LSW_LG, N = 1 << N_LG, LPW = 1 << (LSW_LG - N_LG);
  localparam int NWIN = 7;
  localparam int RUNC = LSW + (NWIN - 1) * LPW + 1;
  localparam longint SMAXV = (64'd1 << SIG_W) - 1;

  // stimulus vectors {mode, a, b, len}: mode 0 constant a, 1 alternating a/b
  // every len cycles, 2 a for len cycles then b, 3 staircase (k/len)%16.
  // Expected values are computed per vector by the model below.
  localparam int NPAT = 5;
  localparam logic [17:0] PATS [NPAT] = '{
    {2'd0, 4'd1,  4'd0, 8'd0},
    {2'd1, 4'd4,  4'd0, 8'd5},
    {2'd2, 4'd15, 4'd0, 8'd40},
    {2'd3, 4'd0,  4'd0, 8'd6},
    {2'd1, 4'd2,  4'd1, 8'd3}
  };

  logic clk = 0, rst = 1, en = 0;
  logic [CNT_W-1:0] cnt_in = '0;
  logic [SIG_W-1:0] sigma_pred;
  logic [FRAC:0]    rho_pred;
  logic             pred_valid;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint rm [NWIN];
  longint sm [NWIN];

  flow_profiler #(.CNT_W(CNT_W), .FRAC(FRAC), .LSW_LG(LSW_LG), .N_LG(N_LG)) uut (
    .clk(clk), .rst(rst), .en(en), .cnt_in(cnt_in),
    .sigma_pred(sigma_pred), .rho_pred(rho_pred), .pred_valid(pred_valid));

  always #10ns clk = ~clk;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cnt_at(logic [17:0] p, int k);
    int a = int'(p[15:12]), b = int'(p[11:8]), len = int'(p[7:0]);
    case (p[17:16])
      2'd0: return a;
      2'd1: return ((k / len) % 2 == 0) ? a : b;
      2'd2: return (k < len) ? a : b;
      default: return (k / len) % 16;
    endcase
  endfunction

  // R2/R3 reference measurements of every window
  task automatic model(logic [17:0] p);
    for (int j = 0; j < NWIN; j++) begin
      longint f = 0, best = 0, d;
      longint rref = (j >= N) ? rm[j-N] : 0;
      for (int t = 1; t <= LSW; t++) begin
        f += cnt_at(p, j * LPW + t - 1);
        d = f * (64'd1 << FRAC) - rref * t;
        if (d > best) best = d;
      end
      sm[j] = best;
      rm[j] = (f * (64'd1 << FRAC)) >> LSW_LG;
    end
  endtask

  task automatic run_phase(logic [17:0] p, int ncyc, bit collide);
    en = 0; cnt_in = '0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check(pred_valid == 0, "R7 idle strobe", pred_valid, 0);
    end
    model(p);
    for (int k = 0; k < ncyc; k++) begin
      bit ev;
      int j;
      cnt_in = CNT_W'(cnt_at(p, k));
      en = 1;
      @(posedge clk); @(negedge clk);
      ev = (k >= LSW + LPW) && ((k - LSW) % LPW == 0);
      check(pred_valid == ev, "R6 strobe timing", pred_valid, ev);
      if (ev) begin
        longint es, er;
        j  = (k - LSW) / LPW;
        es = 2 * sm[j] - sm[j-1];
        er = 2 * rm[j] - rm[j-1];
        if (es < 0) es = 0;
        if (es > SMAXV) es = SMAXV;
        if (er < 0) er = 0;
        if (er > (64'd1 << FRAC)) er = 64'd1 << FRAC;
        check(sigma_pred == es, "R3 R4 R5 burst prediction", sigma_pred, es);
        check(rho_pred == er, "R2 R4 R5 rate prediction", rho_pred, er);
      end
    end
    if (collide) begin
      en = 0;
      for (int i = 0; i < 4; i++) begin
        @(posedge clk); @(negedge clk);
        check(pred_valid == 0, "R7 close while disabled", pred_valid, 0);
      end
    end
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pred_valid == 0, "R8 reset strobe", pred_valid, 0);
    check(sigma_pred == 0, "R8 reset burst", sigma_pred, 0);
    check(rho_pred == 0, "R8 reset rate", rho_pred, 0);
    rst = 0; en = 0;
    // table walk
    for (int i = 0; i < NPAT; i++) run_phase(PATS[i], RUNC, 1'b0);
    // R7: window 1 closes in the cycle en falls; no strobe, history cleared
    run_phase(PATS[0], LSW + LPW, 1'b1);
    run_phase(PATS[1], RUNC, 1'b0);
    // R8: reset while running clears outputs
    rst = 1;
    @(posedge clk); @(negedge clk);
    check(pred_valid == 0, "R8 midrun strobe", pred_valid, 0);
    check(sigma_pred == 0, "R8 midrun burst", sigma_pred, 0);
    check(rho_pred == 0, "R8 midrun rate", rho_pred, 0);
    rst = 0;
    run_phase(PATS[2], RUNC, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule